// File: doc/BRIEF.md
# Serial ADC Conversion and Calibration Sequencer

This block sits on the host side of a 16-bit successive-approximation converter that has a serial output and no clock of its own. The host must drive every converter clock edge. On a start request the sequencer runs one of two operations. A conversion holds the sample strobe low for a minimum time, then holds it high for the acquisition window and the first-clock delay, and then issues exactly 17 converter clock pulses. A calibration raises the calibration strobe for a fixed time and then issues a long, fixed train of converter clock pulses, which may run at a faster rate.

During a conversion the converter returns one data bit per clock, most significant bit first, together with its own serial strobe. The sequencer passes the busy line, the data line and the strobe through two-flop synchronisers, then shifts a data bit in on each rising edge of the synchronised strobe. An operation finishes when two conditions both hold: a minimum tail time has passed since the last clock, and busy has been seen low. A finished conversion presents the 16-bit word with a one-cycle valid pulse. If busy stays high too long, the sequencer sets an error flag and returns to idle. Every time is a parameter given as a count of system-clock cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and conv_clk_o, sample_o, cal_o, valid_o, timeout_err_o and result_o are all 0.
- R2: After a conversion start is accepted, sample_o stays low for exactly SMP_LO_CYC cycles. It then stays high for exactly ACQ_CYC + FCD_CYC cycles, and it falls in the same cycle in which conv_clk_o first rises. sample_o is never high while conv_clk_o is high.
- R3: A conversion issues exactly 17 conv_clk_o pulses. Each pulse is high for CLK_HI_CYC cycles and is followed by CLK_LO_CYC low cycles.
- R4: A calibration (start_i with cal_i = 1) holds cal_o high for exactly CAL_STB_CYC cycles. It then issues exactly CAL_PULSES pulses of CAL_CLK_HI_CYC high and CAL_CLK_LO_CYC low cycles. sample_o stays low and valid_o is never raised.
- R5: Data bits are taken on rising edges of the returned serial clock, most significant first. The first bit lands in result_o[15]. On completion result_o holds the 16 bits and valid_o is high for exactly one cycle.
- R6: Completion waits for both conditions: LCS_CYC cycles after the last low phase, and busy seen low. With busy already low, valid_o rises CLK_LO_CYC + LCS_CYC cycles after the last conv_clk_o fall. With busy falling later, valid_o rises 2 to 3 cycles after busy falls.
- R7: If busy is still high TIMEOUT_CYC cycles after the last low phase ends, timeout_err_o goes to 1 and ready_o returns, CLK_LO_CYC + TIMEOUT_CYC cycles after the last conv_clk_o fall. valid_o stays low and result_o keeps its previous value. The flag clears when the next start is accepted.
- R8: start_i and cal_i are ignored while ready_o is 0. The running operation keeps its pulse count and mode, and it gives exactly one result.
- R9: ready_o is 1 exactly when the sequencer is idle, and it rises in the same cycle as valid_o. A start_i that is high in that cycle is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while ready_o is 1 |
| cal_i | input | 1 | Operation select at start: 1 = calibration, 0 = conversion |
| busy_i | input | 1 | Busy line from the converter (asynchronous) |
| sdata_i | input | 1 | Serial data from the converter (asynchronous) |
| sclk_i | input | 1 | Serial data strobe returned by the converter (asynchronous) |
| conv_clk_o | output | 1 | Generated converter clock |
| sample_o | output | 1 | Sample strobe |
| cal_o | output | 1 | Calibration strobe |
| result_o | output | 16 | Last converted word |
| valid_o | output | 1 | One-cycle pulse when result_o is updated |
| ready_o | output | 1 | Sequencer idle, start accepted |
| timeout_err_o | output | 1 | Busy did not fall within the timeout |

## Verification
Two functions can fall in the same cycle: the completion of one conversion, where valid_o and ready_o rise together, and the acceptance of the next start request. The bench provokes this by raising start_i in the very cycle it sees valid_o. It judges the outcome in three ways: ready_o must drop at the following edge, the strobe low time must count from there, and the second word must be captured with its full 17-pulse train. A second case puts the busy fall well after the tail time, which separates the two completion conditions.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    localparam int unsigned RES_BITS    = 16;
    localparam int unsigned CONV_PULSES = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL_STB,
        ST_SMP_LO,
        ST_ACQ,
        ST_FCD,
        ST_CLOCK,
        ST_TAIL
    } seq_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_d, meta_q, stab_d, stab_q;

    always_comb begin
        meta_d = d_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/adc_seq_clkgen.sv
`timescale 1ns/1ps
module adc_seq_clkgen import adc_seq_pkg::*; #(
    parameter int unsigned HI_CYC     = 37,
    parameter int unsigned LO_CYC     = 36,
    parameter int unsigned CAL_HI_CYC = 30,
    parameter int unsigned CAL_LO_CYC = 30,
    parameter int unsigned CAL_PULSES = 85532
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic cal_mode_i,
    output logic clk_o,
    output logic done_o
);
    localparam int unsigned PH_MAX = umax(umax(HI_CYC, LO_CYC), umax(CAL_HI_CYC, CAL_LO_CYC));
    localparam int unsigned PHW    = $clog2(PH_MAX + 1);
    localparam int unsigned NW     = $clog2(umax(CAL_PULSES, CONV_PULSES) + 1);

    typedef struct packed {
        logic           run;
        logic           cal;
        logic           lvl;
        logic [PHW-1:0] ph;
        logic [NW-1:0]  left;
    } gen_t;

    gen_t gen_d, gen_q;
    logic done_d;

    always_comb begin
        gen_d  = gen_q;
        done_d = 1'b0;
        if (go_i) begin
            gen_d.run  = 1'b1;
            gen_d.cal  = cal_mode_i;
            gen_d.lvl  = 1'b1;
            gen_d.ph   = cal_mode_i ? PHW'(CAL_HI_CYC - 1) : PHW'(HI_CYC - 1);
            gen_d.left = cal_mode_i ? NW'(CAL_PULSES) : NW'(CONV_PULSES);
        end else if (gen_q.run) begin
            if (gen_q.ph != '0) begin
                gen_d.ph = gen_q.ph - 1'b1;
            end else if (gen_q.lvl) begin
                gen_d.lvl = 1'b0;
                gen_d.ph  = gen_q.cal ? PHW'(CAL_LO_CYC - 1) : PHW'(LO_CYC - 1);
            end else if (gen_q.left == NW'(1)) begin
                gen_d.run = 1'b0;
                done_d    = 1'b1;
            end else begin
                gen_d.left = gen_q.left - 1'b1;
                gen_d.lvl  = 1'b1;
                gen_d.ph   = gen_q.cal ? PHW'(CAL_HI_CYC - 1) : PHW'(HI_CYC - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign clk_o  = gen_q.lvl;
    assign done_o = done_d;

    // pulse counter kept only for the checks below
    logic [NW-1:0] rises_q;
    logic          lvl_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rises_q    <= '0;
            lvl_prev_q <= 1'b0;
        end else begin
            lvl_prev_q <= gen_q.lvl;
            if (go_i)                          rises_q <= '0;
            else if (gen_q.lvl && !lvl_prev_q) rises_q <= rises_q + 1'b1;
        end
    end

    // R3 R4
    pulse_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rises_q == (gen_q.cal ? NW'(CAL_PULSES) : NW'(CONV_PULSES)));

    // R3
    done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !clk_o);
endmodule

// File: rtl/adc_seq_capture.sv
`timescale 1ns/1ps
module adc_seq_capture #(
    parameter int unsigned W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   en_i,
    input  logic                   sclk_i,
    input  logic                   sdata_i,
    output logic [W-1:0]           word_o,
    output logic [$clog2(W+1)-1:0] count_o
);
    localparam int unsigned CNW = $clog2(W + 1);

    typedef struct packed {
        logic           prev;
        logic [W-1:0]   sh;
        logic [CNW-1:0] n;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = sclk_i;
        if (clr_i) begin
            cap_d.sh = '0;
            cap_d.n  = '0;
        end else if (en_i && sclk_i && !cap_q.prev && cap_q.n < CNW'(W)) begin
            cap_d.sh = {cap_q.sh[W-2:0], sdata_i};
            cap_d.n  = cap_q.n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign word_o  = cap_q.sh;
    assign count_o = cap_q.n;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl import adc_seq_pkg::*; #(
    parameter int unsigned SMP_LO_CYC     = 13,
    parameter int unsigned ACQ_CYC        = 250,
    parameter int unsigned FCD_CYC        = 7,
    parameter int unsigned CAL_STB_CYC    = 7,
    parameter int unsigned CLK_HI_CYC     = 37,
    parameter int unsigned CLK_LO_CYC     = 36,
    parameter int unsigned CAL_CLK_HI_CYC = 30,
    parameter int unsigned CAL_CLK_LO_CYC = 30,
    parameter int unsigned CAL_PULSES     = 85532,
    parameter int unsigned LCS_CYC        = 263,
    parameter int unsigned TIMEOUT_CYC    = 125000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cal_i,
    input  logic                busy_i,
    input  logic                sdata_i,
    input  logic                sclk_i,
    output logic                conv_clk_o,
    output logic                sample_o,
    output logic                cal_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                valid_o,
    output logic                ready_o,
    output logic                timeout_err_o
);
    localparam int unsigned CNT_MAX = umax(umax(umax(SMP_LO_CYC, ACQ_CYC), umax(FCD_CYC, CAL_STB_CYC)),
                                           umax(LCS_CYC, TIMEOUT_CYC));
    localparam int unsigned CW  = $clog2(CNT_MAX + 1);
    localparam int unsigned CNW = $clog2(RES_BITS + 1);

    typedef struct packed {
        seq_state_e          st;
        logic [CW-1:0]       cnt;
        logic                is_cal;
        logic                sample;
        logic                cal;
        logic                ready;
        logic                valid;
        logic                err;
        logic [RES_BITS-1:0] result;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cnt: '0, is_cal: 1'b0, sample: 1'b0, cal: 1'b0,
                                 ready: 1'b1, valid: 1'b0, err: 1'b0, result: '0};

    ctl_t ctl_d, ctl_q;

    logic [2:0]          async_in, sync_out;
    logic                busy_s, sdata_s, sclk_s;
    logic                go_w, clr_w, gen_done_w, gen_clk_w;
    logic [RES_BITS-1:0] cap_word_w;
    logic [CNW-1:0]      cap_count_w;

    assign async_in = {busy_i, sdata_i, sclk_i};

    adc_seq_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (async_in),
        .q_o   (sync_out)
    );

    assign busy_s  = sync_out[2];
    assign sdata_s = sync_out[1];
    assign sclk_s  = sync_out[0];

    adc_seq_clkgen #(
        .HI_CYC     (CLK_HI_CYC),
        .LO_CYC     (CLK_LO_CYC),
        .CAL_HI_CYC (CAL_CLK_HI_CYC),
        .CAL_LO_CYC (CAL_CLK_LO_CYC),
        .CAL_PULSES (CAL_PULSES)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_w),
        .cal_mode_i (ctl_q.is_cal),
        .clk_o      (gen_clk_w),
        .done_o     (gen_done_w)
    );

    adc_seq_capture #(.W(RES_BITS)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_w),
        .en_i    (ctl_q.st == ST_CLOCK),
        .sclk_i  (sclk_s),
        .sdata_i (sdata_s),
        .word_o  (cap_word_w),
        .count_o (cap_count_w)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        go_w        = 1'b0;
        clr_w       = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    clr_w        = 1'b1;
                    ctl_d.err    = 1'b0;
                    ctl_d.is_cal = cal_i;
                    if (cal_i) begin
                        ctl_d.st  = ST_CAL_STB;
                        ctl_d.cnt = CW'(CAL_STB_CYC - 1);
                    end else begin
                        ctl_d.st  = ST_SMP_LO;
                        ctl_d.cnt = CW'(SMP_LO_CYC - 1);
                    end
                end
            end
            ST_CAL_STB, ST_ACQ: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_FCD;
                    ctl_d.cnt = CW'(FCD_CYC - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_SMP_LO: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_ACQ;
                    ctl_d.cnt = CW'(ACQ_CYC - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_FCD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_CLOCK;
                    go_w     = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_CLOCK: begin
                if (gen_done_w) begin
                    ctl_d.st  = ST_TAIL;
                    ctl_d.cnt = '0;
                end
            end
            ST_TAIL: begin
                if (!busy_s && ctl_q.cnt >= CW'(LCS_CYC - 1)) begin
                    ctl_d.st = ST_IDLE;
                    if (!ctl_q.is_cal) begin
                        ctl_d.valid  = 1'b1;
                        ctl_d.result = cap_word_w;
                    end
                end else if (busy_s && ctl_q.cnt >= CW'(TIMEOUT_CYC - 1)) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        ctl_d.sample = (ctl_d.st == ST_ACQ || ctl_d.st == ST_FCD) && !ctl_d.is_cal;
        ctl_d.cal    = (ctl_d.st == ST_CAL_STB);
        ctl_d.ready  = (ctl_d.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign conv_clk_o    = gen_clk_w;
    assign sample_o      = ctl_q.sample;
    assign cal_o         = ctl_q.cal;
    assign result_o      = ctl_q.result;
    assign valid_o       = ctl_q.valid;
    assign ready_o       = ctl_q.ready;
    assign timeout_err_o = ctl_q.err;

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!sample_o && !cal_o && !conv_clk_o));

    // R2
    sample_clock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !conv_clk_o);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_o |-> !sample_o);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    valid_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cap_count_w == CNW'(RES_BITS)));

    // R7
    err_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> (ready_o && !valid_o));
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    localparam int T_SMP_LO = 13;
    localparam int T_ACQ    = 40;
    localparam int T_FCD    = 7;
    localparam int T_CALSTB = 8;
    localparam int T_HI     = 20;
    localparam int T_LO     = 20;
    localparam int T_CHI    = 8;
    localparam int T_CLO    = 8;
    localparam int T_CALN   = 12;
    localparam int T_LCS    = 30;
    localparam int T_TMO    = 200;

    localparam logic [15:0] VEC [6] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'h7FFE};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, cal_i = 1'b0;
    logic busy = 1'b0, sdata = 1'b0, sclk = 1'b0;
    logic conv_clk_o, sample_o, cal_o, valid_o, ready_o, timeout_err_o;
    logic [15:0] result_o;

    always #4 clk = ~clk;

    adc_seq_ctrl #(
        .SMP_LO_CYC(T_SMP_LO), .ACQ_CYC(T_ACQ), .FCD_CYC(T_FCD), .CAL_STB_CYC(T_CALSTB),
        .CLK_HI_CYC(T_HI), .CLK_LO_CYC(T_LO), .CAL_CLK_HI_CYC(T_CHI), .CAL_CLK_LO_CYC(T_CLO),
        .CAL_PULSES(T_CALN), .LCS_CYC(T_LCS), .TIMEOUT_CYC(T_TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_i(cal_i),
        .busy_i(busy), .sdata_i(sdata), .sclk_i(sclk),
        .conv_clk_o(conv_clk_o), .sample_o(sample_o), .cal_o(cal_o),
        .result_o(result_o), .valid_o(valid_o), .ready_o(ready_o),
        .timeout_err_o(timeout_err_o)
    );

    int checks = 0, errors = 0;
    logic [15:0] cur_word = '0;
    bit stall = 1'b0;
    int busy_ns = 101;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model
    initial begin
        forever begin
            @(posedge sample_o or posedge cal_o);
            if (cal_o) begin
                #20 busy = 1'b1;
                for (int i = 0; i < T_CALN; i++) @(posedge conv_clk_o);
                #101 busy = 1'b0;
            end else begin
                #20 busy = 1'b1;
                for (int b = 15; b >= 0; b--) begin
                    @(posedge conv_clk_o);
                    #43 sdata = cur_word[b];
                    #57 sclk = 1'b1;
                    @(negedge conv_clk_o);
                    sclk = 1'b0;
                end
                @(posedge conv_clk_o);
                if (!stall) #(busy_ns) busy = 1'b0;
            end
        end
    end

    // output monitor, 2 ns after each edge
    int cyc = 0, pulses, hi_min, hi_max, lo_min, lo_max, hi_run, lo_run;
    int samp_hi, acq_meas, smplo_run, smplo_meas, cal_hi, valid_cnt;
    int fall_cyc, valid_cyc, busy_fall_cyc, ready_cyc;
    bit samp_seen;
    logic pc = 0, pb = 0, pr = 0, ps = 0;
    logic [15:0] got;

    task automatic clr_mon();
        pulses = 0; hi_min = 1 << 20; hi_max = 0; lo_min = 1 << 20; lo_max = 0;
        hi_run = 0; lo_run = 0; samp_hi = 0; acq_meas = -1; smplo_run = 0; smplo_meas = -1;
        cal_hi = 0; valid_cnt = 0; fall_cyc = 0; valid_cyc = 0; busy_fall_cyc = 0;
        ready_cyc = 0; samp_seen = 0;
    endtask

    always @(posedge clk) begin
        #2;
        cyc++;
        if (conv_clk_o && !pc) begin
            if (pulses == 0) acq_meas = samp_hi;
            else begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            lo_run = 0;
            pulses++;
        end
        if (!conv_clk_o && pc) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
            fall_cyc = cyc;
        end
        if (conv_clk_o) hi_run++; else lo_run++;
        if (sample_o) samp_hi++;
        if (sample_o && !ps && !samp_seen) begin
            smplo_meas = smplo_run;
            samp_seen = 1;
        end
        if (!ready_o && !sample_o && !samp_seen && pulses == 0) smplo_run++;
        if (cal_o) cal_hi++;
        if (valid_o) begin valid_cnt++; valid_cyc = cyc; got = result_o; end
        if (!busy && pb) busy_fall_cyc = cyc;
        if (ready_o && !pr) ready_cyc = cyc;
        pc = conv_clk_o; pb = busy; pr = ready_o; ps = sample_o;
    end

    task automatic issue(input bit cal, input logic [15:0] w);
        @(negedge clk);
        clr_mon();
        cur_word = w; cal_i = cal; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; cal_i = 1'b0;
    endtask

    task automatic wait_done(input bit junk);
        int n = 0;
        do begin
            @(posedge clk); #3;
            n++;
            if (junk && (n == 5 || n == 120 || n == 500)) begin
                start_i = 1'b1; cal_i = 1'b1;
            end else begin
                start_i = 1'b0; cal_i = 1'b0;
            end
        end while (!ready_o && n < 4000);
        start_i = 1'b0; cal_i = 1'b0;
    endtask

    task automatic check_conv(input logic [15:0] w, input string tag);
        chk(got == w && valid_cnt == 1, {tag, " R5 result"}, int'(got), int'(w));
        chk(pulses == 17, {tag, " R3 pulses"}, pulses, 17);
        chk(hi_min == T_HI && hi_max == T_HI, {tag, " R3 high phase"}, hi_max, T_HI);
        chk(lo_min == T_LO && lo_max == T_LO, {tag, " R3 low phase"}, lo_max, T_LO);
        chk(acq_meas == T_ACQ + T_FCD, {tag, " R2 sample high"}, acq_meas, T_ACQ + T_FCD);
        chk(smplo_meas == T_SMP_LO, {tag, " R2 sample low"}, smplo_meas, T_SMP_LO);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_mon();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
        chk(conv_clk_o == 1'b0 && sample_o == 1'b0 && cal_o == 1'b0, "R1 strobes", int'({conv_clk_o, sample_o, cal_o}), 0);
        chk(valid_o == 1'b0 && timeout_err_o == 1'b0, "R1 flags", int'({valid_o, timeout_err_o}), 0);
        chk(result_o == 16'h0, "R1 result", int'(result_o), 0);

        // vector table: conversions
        for (int v = 0; v < 6; v++) begin
            issue(1'b0, VEC[v]);
            wait_done(1'b0);
            check_conv(VEC[v], "vec");
            chk(valid_cyc - fall_cyc == T_LO + T_LCS, "R6 tail time", valid_cyc - fall_cyc, T_LO + T_LCS);
            chk(valid_cyc == ready_cyc, "R9 ready with valid", ready_cyc, valid_cyc);
        end

        // calibration
        issue(1'b1, 16'h0);
        wait_done(1'b0);
        chk(cal_hi == T_CALSTB, "R4 cal strobe", cal_hi, T_CALSTB);
        chk(pulses == T_CALN, "R4 cal pulses", pulses, T_CALN);
        chk(hi_min == T_CHI && hi_max == T_CHI, "R4 cal high", hi_max, T_CHI);
        chk(lo_min == T_CLO && lo_max == T_CLO, "R4 cal low", lo_max, T_CLO);
        chk(samp_hi == 0 && valid_cnt == 0, "R4 no sample no valid", samp_hi + valid_cnt, 0);
        chk(result_o == VEC[5], "R4 result kept", int'(result_o), int'(VEC[5]));

        // start requests during a conversion are ignored
        issue(1'b0, 16'h5A3C);
        wait_done(1'b1);
        check_conv(16'h5A3C, "ignore");
        chk(cal_hi == 0, "R8 no calibration strobe", cal_hi, 0);
        @(posedge clk); #3;
        chk(ready_o == 1'b1, "R8 stays idle", ready_o, 1);

        // late busy fall
        busy_ns = 803;
        issue(1'b0, 16'hC0DE);
        wait_done(1'b0);
        busy_ns = 101;
        chk(got == 16'hC0DE, "R6 late result", int'(got), int'(16'hC0DE));
        chk(valid_cyc - busy_fall_cyc >= 2 && valid_cyc - busy_fall_cyc <= 3, "R6 waits busy",
            valid_cyc - busy_fall_cyc, 2);
        chk(valid_cyc - fall_cyc > T_LO + T_LCS, "R6 beyond tail", valid_cyc - fall_cyc, T_LO + T_LCS + 1);

        // busy stuck high
        stall = 1'b1;
        issue(1'b0, 16'h0F0F);
        wait_done(1'b0);
        chk(timeout_err_o == 1'b1, "R7 error flag", timeout_err_o, 1);
        chk(valid_cnt == 0, "R7 no valid", valid_cnt, 0);
        chk(result_o == 16'hC0DE, "R7 result kept", int'(result_o), int'(16'hC0DE));
        chk(ready_cyc - fall_cyc == T_LO + T_TMO, "R7 timeout time", ready_cyc - fall_cyc, T_LO + T_TMO);
        @(negedge clk);
        stall = 1'b0; busy = 1'b0;

        // start accepted in the completion cycle
        issue(1'b0, 16'h3C96);
        #1;
        chk(timeout_err_o == 1'b0, "R7 error cleared", timeout_err_o, 0);
        wait_done(1'b0);
        check_conv(16'h3C96, "first");
        clr_mon();
        cur_word = 16'h6E17;
        start_i = 1'b1;
        @(posedge clk); #3;
        chk(ready_o == 1'b0, "R9 start in valid cycle", ready_o, 0);
        start_i = 1'b0;
        wait_done(1'b0);
        check_conv(16'h6E17, "R9 back to back");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule